// File: doc/BRIEF.md
# Four-Phase Stepper Coil Sequencer

This block drives the four windings of a unipolar stepper motor that spins while a lock stands open. It keeps a one-hot word naming the energised winding and moves that word one place per step. A direction flag sets which way the word moves, and the drive pins are active low.

Two single-cycle toggle inputs control the block. One starts and stops rotation. The other reverses it. Each toggle input acts on its rising edge only. The lock verdict comes in as an enable: while the enable is low no step is taken, whatever the run flag says. Steps come from a strobe that fires once every `STEP_DIV` clock cycles. There is no divided clock. If the one-hot word is ever corrupted, the next step reloads a start pattern that depends on the direction.

Top module: `stp_coil_seq`

## Requirements
- R1: After reset the internal word is 0001, so `coil_o` reads 1110. Rotation is stopped and the direction is forward.
- R2: In forward direction each step shifts the word one bit toward the MSB, and bit 3 wraps into bit 0. The sequence is 0001, 0010, 0100, 1000, 0001.
- R3: In reverse direction each step shifts the word one bit toward the LSB, and bit 0 wraps into bit 3. The sequence is 0001, 1000, 0100, 0010.
- R4: Each 0-to-1 transition on `run_tgl_i` flips the running flag exactly once. Holding the input high causes no further flips.
- R5: Each 0-to-1 transition on `dir_tgl_i` flips the direction flag exactly once (0 = forward, 1 = reverse). Holding the input high causes no further flips.
- R6: With `STEP_DIV` = 2, a step happens on every second clock edge while running and enabled. The first step comes on the second edge after the gate opens, so a gate held open for 2n edges yields n steps.
- R7: While `en_i` is low the coil pattern does not change.
- R8: While the running flag is clear the coil pattern holds its last value.
- R9: A word that is not one-hot (0000 or 1001, for example) is replaced on the next step. The replacement is 0001 in forward direction and 1000 in reverse.
- R10: `coil_o` is the bitwise inverse of the internal one-hot word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_tgl_i | input | 1 | Rising edge starts or stops rotation |
| dir_tgl_i | input | 1 | Rising edge reverses rotation |
| en_i | input | 1 | Lock-open enable; stepping only while high |
| coil_o | output | PHASES | Active-low winding drive |

## Verification
The toggle-edge properties assume that the toggle inputs are low when reset is released. The hold property on the enable assumes the internal word changes only through a step. The stimulus meets both conditions. Every input change is made at the falling clock edge, and both toggle inputs stay low through reset. A corrupted word is written in only while the enable is high and the motor is stopped, so no step-related property sees a write that did not come from a step. The table-driven part always pulses the toggles for exactly one cycle. The directed part deliberately holds them high for several cycles to expose level-sensitive toggling.

// File: rtl/stp_pkg.sv
package stp_pkg;
   typedef enum logic {
      DIR_FWD = 1'b0,
      DIR_REV = 1'b1
   } stp_dir_e;
endpackage

// File: rtl/stp_toggle.sv
module stp_toggle #(
   parameter bit INIT = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic flag_o
);
   logic prev_q;
   logic flag_q;
   logic rise;

   always_comb rise = lvl_i && !prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         flag_q <= INIT;
      end else begin
         prev_q <= lvl_i;
         flag_q <= flag_q ^ rise;
      end
   end

   assign flag_o = flag_q;

   // R4, R5: a level held high flips the flag no more than once
   assert_toggle_once_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(lvl_i) && $past(lvl_i, 2)) |-> (flag_o == $past(flag_o)));

   // R4, R5: a fresh rising edge always flips the flag
   assert_toggle_flips_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_i && !prev_q) |=> (flag_o != $past(flag_o)));
endmodule

// File: rtl/stp_strobe.sv
module stp_strobe #(
   parameter int unsigned DIV = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic gate_i,
   output logic step_o
);
   if (DIV < 1) begin : g_bad_div
      $error("stp_strobe: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_direct
      assign step_o = gate_i;
   end else begin : g_count
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cnt_q <= '0;
         end else if (!gate_i) begin
            cnt_q <= '0;
         end else if (cnt_q == LAST) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign step_o = gate_i && (cnt_q == LAST);

      // R6: steps never come on adjacent edges
      assert_step_spacing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         step_o |=> !step_o);

      // R6: the first step needs the gate open on the preceding edge too
      assert_first_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         step_o |-> $past(gate_i));
   end
endmodule

// File: rtl/stp_ring.sv
module stp_ring
   import stp_pkg::*;
#(
   parameter int unsigned PH = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          step_i,
   input  stp_dir_e      dir_i,
   output logic [PH-1:0] state_o
);
   if (PH < 2) begin : g_bad_ph
      $error("stp_ring: PH must be at least 2");
   end

   localparam logic [PH-1:0] FWD_START = PH'(1);
   localparam logic [PH-1:0] REV_START = {1'b1, {(PH-1){1'b0}}};

   logic [PH-1:0] state_q;
   logic [PH-1:0] nxt;
   logic          legal;

   always_comb legal = ($countones(state_q) == 1);

   always_comb begin
      if (!legal) begin
         nxt = (dir_i == DIR_FWD) ? FWD_START : REV_START;
      end else if (dir_i == DIR_FWD) begin
         nxt = {state_q[PH-2:0], state_q[PH-1]};
      end else begin
         nxt = {state_q[0], state_q[PH-1:1]};
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= FWD_START;
      end else if (step_i) begin
         state_q <= nxt;
      end
   end

   assign state_o = state_q;

   // R2, R3, R9: every step leaves a one-hot word
   assert_onehot_after_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(step_i) |-> $onehot(state_q));

   assert_fwd_rotate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(step_i) && ($past(dir_i) == DIR_FWD) && ($countones($past(state_q)) == 1))
      |-> (state_q == {$past(state_q[PH-2:0]), $past(state_q[PH-1])}));

   assert_rev_rotate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(step_i) && ($past(dir_i) == DIR_REV) && ($countones($past(state_q)) == 1))
      |-> (state_q == {$past(state_q[0]), $past(state_q[PH-1:1])}));

   assert_recover_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(step_i) && ($countones($past(state_q)) != 1))
      |-> (state_q == (($past(dir_i) == DIR_FWD) ? FWD_START : REV_START)));
endmodule

// File: rtl/stp_coil_seq.sv
module stp_coil_seq
   import stp_pkg::*;
#(
   parameter int unsigned PHASES     = 4,
   parameter int unsigned STEP_DIV   = 2,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_tgl_i,
   input  logic              dir_tgl_i,
   input  logic              en_i,
   output logic [PHASES-1:0] coil_o
);
   logic              run_q;
   logic              dir_flag;
   stp_dir_e          dir;
   logic              gate;
   logic              step;
   logic [PHASES-1:0] state;

   stp_toggle #(.INIT(1'b0)) u_run (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (run_tgl_i),
      .flag_o (run_q)
   );

   stp_toggle #(.INIT(1'b0)) u_dir (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (dir_tgl_i),
      .flag_o (dir_flag)
   );

   assign dir  = stp_dir_e'(dir_flag);
   assign gate = run_q && en_i;

   stp_strobe #(.DIV(STEP_DIV)) u_strobe (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .gate_i (gate),
      .step_o (step)
   );

   stp_ring #(.PH(PHASES)) u_ring (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (step),
      .dir_i   (dir),
      .state_o (state)
   );

   if (ACTIVE_LOW) begin : g_drive_low
      assign coil_o = ~state;
   end else begin : g_drive_high
      assign coil_o = state;
   end

   // R7: with the enable low the drive pattern does not move
   assert_hold_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(!en_i) |-> $stable(coil_o));

   // R8: no step is taken while the run flag is clear
   assert_no_step_stopped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_q |-> !step);
endmodule

// File: tb/tb_stp_coil_seq.sv
`timescale 1ns/1ps
module tb_stp_coil_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_t = 1'b0;
   logic       dir_t = 1'b0;
   logic       en = 1'b1;
   logic [3:0] coil;
   int         n_chk = 0;
   int         n_err = 0;
   bit         done = 1'b0;
   logic [3:0] st;
   logic       rev;

   always #4 clk = ~clk;

   stp_coil_seq #(.PHASES(4), .STEP_DIV(2), .ACTIVE_LOW(1'b1)) dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .run_tgl_i (run_t),
      .dir_tgl_i (dir_t),
      .en_i      (en),
      .coil_o    (coil)
   );

   // table entry: {flip direction first, step count, expected coil}
   localparam int NV = 8;
   localparam logic [8:0] VEC [NV] = '{
      {1'b0, 4'd1, 4'b1101},
      {1'b0, 4'd2, 4'b0111},
      {1'b0, 4'd1, 4'b1110},
      {1'b1, 4'd1, 4'b0111},
      {1'b0, 4'd2, 4'b1101},
      {1'b0, 4'd3, 4'b1011},
      {1'b1, 4'd1, 4'b0111},
      {1'b0, 4'd5, 4'b1110}
   };

   function automatic logic [3:0] model_next(logic [3:0] s, logic r);
      if ($countones(s) != 1) return r ? 4'b1000 : 4'b0001;
      return r ? {s[0], s[3:1]} : {s[2:0], s[3]};
   endfunction

   task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: coil=%b expected %b", req, act, exp);
      end
   endtask

   task automatic chk_ne(string req, logic [3:0] act, logic [3:0] old);
      n_chk++;
      if (act === old) begin
         n_err++;
         $display("FAIL %s: coil=%b expected a change from %b", req, act, old);
      end
   endtask

   task automatic pulse_run();
      @(negedge clk) run_t = 1'b1;
      @(negedge clk) run_t = 1'b0;
   endtask

   task automatic pulse_dir();
      @(negedge clk) dir_t = 1'b1;
      @(negedge clk) dir_t = 1'b0;
      rev = ~rev;
   endtask

   // start, keep the gate open for 2n edges, stop: exactly n steps
   task automatic run_steps(int n);
      pulse_run();
      repeat (2 * n - 1) @(negedge clk);
      run_t = 1'b1;
      @(negedge clk) run_t = 1'b0;
      for (int i = 0; i < n; i++) st = model_next(st, rev);
   endtask

   initial begin
      logic [3:0] c0;
      rev = 1'b0;
      st  = 4'b0001;
      repeat (3) @(negedge clk);
      chk("R1 reset drive", coil, 4'b1110);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 inverse of reset word", coil, ~4'b0001);

      // table: R2 forward, R3 reverse, R5 single direction flips
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][8]) pulse_dir();
         run_steps(int'(VEC[i][7:4]));
         chk($sformatf("R2/R3 vector %0d", i), coil, VEC[i][3:0]);
         chk($sformatf("R10 model vector %0d", i), coil, ~st);
      end

      // R6: step timing after start
      c0 = coil;
      pulse_run();
      chk("R6 no step on start edge", coil, c0);
      @(negedge clk);
      chk("R6 no step one edge later", coil, c0);
      @(negedge clk);
      st = model_next(st, rev);
      chk("R6 step on second edge", coil, ~st);
      run_t = 1'b1;
      @(negedge clk) run_t = 1'b0;
      chk("R6 no step on stop edge", coil, ~st);

      // R4: a held run level toggles only once, so the motor keeps turning
      @(negedge clk) run_t = 1'b1;
      repeat (6) @(negedge clk);
      run_t = 1'b0;
      c0 = coil;
      repeat (2) @(negedge clk);
      chk_ne("R4 still running after held level", coil, c0);
      pulse_run();
      st = ~coil;
      repeat (5) @(negedge clk);
      chk("R8 stopped holds", coil, ~st);

      // R5: a held direction level flips the direction once
      @(negedge clk) dir_t = 1'b1;
      repeat (4) @(negedge clk);
      dir_t = 1'b0;
      rev = ~rev;
      run_steps(1);
      chk("R5 held direction flips once", coil, ~st);

      // R7: enable low blocks stepping even while running
      @(negedge clk) en = 1'b0;
      pulse_run();
      repeat (8) @(negedge clk);
      chk("R7 enable low holds", coil, ~st);
      pulse_run();
      @(negedge clk) en = 1'b1;
      repeat (4) @(negedge clk);
      chk("R8 stopped after enable returns", coil, ~st);
      run_steps(1);
      chk("R7 stepping resumes with enable", coil, ~st);

      // R9: recovery from corrupted words
      if (rev) pulse_dir();
      @(negedge clk) force dut.u_ring.state_q = 4'b1001;
      @(negedge clk) release dut.u_ring.state_q;
      chk("R10 corrupted word inverted", coil, 4'b0110);
      st = 4'b1001;
      run_steps(1);
      chk("R9 forward recovery", coil, 4'b1110);
      @(negedge clk) force dut.u_ring.state_q = 4'b0000;
      @(negedge clk) release dut.u_ring.state_q;
      st = 4'b0000;
      pulse_dir();
      run_steps(1);
      chk("R9 reverse recovery", coil, 4'b0111);

      // R1: reset mid-stream restores word and forward direction
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      chk("R1 reset restores word", coil, 4'b1110);
      rev = 1'b0;
      st  = 4'b0001;
      run_steps(1);
      chk("R1 reset restores forward", coil, 4'b1101);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule